// File: doc/BRIEF.md
# Stereo Pixel Serializer with Lockstep Check

This block turns the parallel pixel stream of one image sensor into a single serial bit stream, one bit per cycle of its clock, which runs at the serial bit rate. Each pixel period becomes one framed word. A word opens with a 1 start bit and closes with a 0 stop bit, and it is sent most significant bit first. In stand-alone mode a word carries the full 10-bit pixel in 12 slots. In stereo mode a word takes 18 slots. It carries the upper 8 bits of the local pixel, followed by an 8-bit pixel that a paired sensor delivers through `peer_byte`.

In stereo mode there are no separate line-valid or frame-valid wires, so both strobes are coded into the byte pairs. Byte values 0x00 and 0x01 are kept for markers, and any real pixel below 0x02 is raised to 0x02. The word after each frame start is a reserved check word. It carries the code 0xA5 from this sensor and the byte received from the paired sensor. If the two differ, a sticky error flag is set, which shows that the two sensors are not in lockstep. A control input replaces the data with a fixed pattern so that a receiver can lock. A soft reset input clears the framing state and the flag.

The block samples all of its inputs on the clock edge that closes a word, that is, the edge right after the cycle in which `word_strobe` is high. It also samples them on the first edge after reset. Those inputs then decide the whole next word, including its length.

Top module: `stpx_serializer`

## Requirements
- R1: Stand-alone mode (`stereo_mode`=0) sends 12 slots, MSB first. The slots are a start bit 1, then `pix_in[9:0]` (or 0x000 while `lv_in` is low), then a stop bit 0.
- R2: Stereo mode sends 18 slots, MSB first. The slots are a start bit 1, then the local byte, then the peer byte, then a stop bit 0. The local byte is `pix_in[9:2]`, and the peer byte is `peer_byte`.
- R3: In a stereo data word, any local or peer byte below 0x02 is sent as 0x02.
- R4: In stereo mode, the word loaded when `fv_in` is high after it was low at the previous load is the frame-start marker. Both of its bytes are 0x00.
- R5: The word after a frame-start marker is the check word. It holds 0xA5 in the local slot and the received `peer_byte` in the peer slot. In stereo mode, a `peer_byte` other than 0xA5 at that word sets `stereo_err`, and the flag stays set until a reset.
- R6: In stereo mode, the first word with `lv_in` high after a word with `lv_in` low is the line-start marker, with both bytes 0x01. If that word would be a frame-start or check word, the line-start marker is sent on the next word instead, before any pixel word.
- R7: In stereo mode, a word with `lv_in` low and no marker due is a blanking word. It carries bytes (0x01, 0x00) while `fv_in` is high and (0x00, 0x01) while `fv_in` is low.
- R8: While `sync_force` is high, each word is a fixed pattern and the framing state does not advance. The pattern is 1 + 0x3E0 + 0 in stand-alone mode and 1 + (0xFF, 0x00) + 0 in stereo mode.
- R9: While `ser_en` is low, `ser_out` stays 0. Words, their timing and the framing state carry on unchanged.
- R10: `soft_rst` high clears the framing state, the error flag and the word timing in the same way as `rst_n` low. After release, the first word starts on the next edge, and a frame already in progress starts again with a frame-start marker.
- R11: During reset, `ser_out`, `word_strobe` and `stereo_err` are all 0.
- R12: `word_strobe` is high for exactly one cycle, on the last slot of each word. The mode sampled at a word's load edge sets that word's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Soft reset, active high |
| stereo_mode | input | 1 | 1 selects the 18-slot merged format |
| sync_force | input | 1 | Send the lock pattern instead of data |
| ser_en | input | 1 | Drive the serial output |
| pix_in | input | 10 | Local pixel |
| lv_in | input | 1 | Line valid |
| fv_in | input | 1 | Frame valid |
| peer_byte | input | 8 | Byte recovered from the paired sensor |
| ser_out | output | 1 | Serial bit |
| word_strobe | output | 1 | High on the last slot of each word |
| stereo_err | output | 1 | Sticky lockstep mismatch flag |

## Verification
On every cycle, the assertions check the word timing. They confirm that the slot count stays in range, that the strobe is a single cycle, that a start bit follows every strobe and that the stop bit falls on the strobe slot. They also check that the error flag only rises after a mismatching check word and never falls outside reset, that no stereo data byte takes a marker value, and that a forced sync pattern leaves the framing state unchanged. Only the bench scenarios can show the choice and order of markers across a frame. These include a line-start deferred past the check word, restart after a soft reset, state held through a sync burst, and the exact bit content of each word.

// File: rtl/stpx_pkg.sv
// Shared types for the stereo pixel serializer.
package stpx_pkg;

    // Classification of the word to be loaded next (stereo framing)
    typedef enum logic [2:0] {
        K_FSTART    = 3'd0,
        K_RESV      = 3'd1,
        K_LSTART    = 3'd2,
        K_PIXEL     = 3'd3,
        K_BLANK_IN  = 3'd4,
        K_BLANK_OUT = 3'd5
    } word_kind_e;

endpackage

// File: rtl/stpx_frame_track.sv
// Frame tracker: decides which kind of word comes next from the line and
// frame strobes, and keeps the lockstep error flag.
// Assumes: `load` is high on the edge where the next word is taken; the
// state only moves on such an edge and never while sync is forced.
module stpx_frame_track
    import stpx_pkg::*;
#(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] RES_CODE = 8'hA5
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              load,
    input  logic              stereo_sel,
    input  logic              sync_force,
    input  logic              fv,
    input  logic              lv,
    input  logic [BYTE_W-1:0] peer,
    output word_kind_e        kind,
    output logic              err_flag
);

    logic fv_prev_q;
    logic res_pend_q;
    logic line_open_q;

    // Priority decode of the next word: frame start, check word, line start, data, blanking
    always_comb begin
        if (fv && !fv_prev_q)       kind = K_FSTART;
        else if (res_pend_q)        kind = K_RESV;
        else if (lv && !line_open_q) kind = K_LSTART;
        else if (lv)                kind = K_PIXEL;
        else if (fv)                kind = K_BLANK_IN;
        else                        kind = K_BLANK_OUT;
    end

    // Advance framing state and latch a mismatch on each accepted word
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            fv_prev_q   <= 1'b0;
            res_pend_q  <= 1'b0;
            line_open_q <= 1'b0;
            err_flag    <= 1'b0;
        end else if (load && !sync_force) begin
            fv_prev_q   <= fv;
            res_pend_q  <= (kind == K_FSTART);
            line_open_q <= lv && (line_open_q || kind == K_LSTART);
            if (stereo_sel && kind == K_RESV && peer != RES_CODE)
                err_flag <= 1'b1;
        end
    end

    // R5: once set, the flag only clears through reset
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!clr_n)
        err_flag |=> err_flag);

    // R5: the flag only rises after a mismatching check word in stereo mode
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(err_flag) |-> $past(load && stereo_sel && kind == K_RESV && peer != RES_CODE));

    // R8: a forced sync word leaves the framing state untouched
    p_sync_holds_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (load && sync_force) |=> ($stable(line_open_q) && $stable(fv_prev_q) && $stable(err_flag)));

endmodule

// File: rtl/stpx_word_build.sv
// Word builder: forms the framed word (start bit, payload, stop bit),
// left-aligned in a SMAX-bit vector so the shifter always sends from its MSB.
// Assumes: SMAX is the larger of the two word lengths.
module stpx_word_build
    import stpx_pkg::*;
#(
    parameter int                PIX_W    = 10,
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] RES_CODE = 8'hA5,
    parameter int                SMAX     = 18
) (
    input  logic              stereo_sel,
    input  logic              sync_force,
    input  logic              lv,
    input  word_kind_e        kind,
    input  logic [PIX_W-1:0]  pix,
    input  logic [BYTE_W-1:0] peer,
    output logic [SMAX-1:0]   word
);

    localparam int SA_SLOTS = PIX_W + 2;
    localparam int ST_SLOTS = 2 * BYTE_W + 2;
    localparam logic [BYTE_W-1:0] MK_ZERO = '0;
    localparam logic [BYTE_W-1:0] MK_ONE  = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] MIN_PIX = BYTE_W'(2);
    localparam logic [PIX_W-1:0]  SA_SYNC = ~PIX_W'((1 << (PIX_W - PIX_W / 2)) - 1);

    logic [PIX_W-1:0]    sa_data;
    logic [BYTE_W-1:0]   byte_a;
    logic [BYTE_W-1:0]   byte_b;
    logic [SA_SLOTS-1:0] sa_word;
    logic [ST_SLOTS-1:0] st_word;

    // Raise data bytes out of the marker range
    function automatic logic [BYTE_W-1:0] lift(input logic [BYTE_W-1:0] v);
        return (v < MIN_PIX) ? MIN_PIX : v;
    endfunction

    // Stand-alone payload: lock pattern, pixel, or zero outside a line
    always_comb begin
        if (sync_force)  sa_data = SA_SYNC;
        else if (lv)     sa_data = pix;
        else             sa_data = '0;
    end

    // Stereo payload: byte pair chosen by the word kind
    always_comb begin
        if (sync_force) begin
            byte_a = '1;
            byte_b = '0;
        end else begin
            case (kind)
                K_FSTART:   begin byte_a = MK_ZERO;  byte_b = MK_ZERO; end
                K_RESV:     begin byte_a = RES_CODE; byte_b = peer;    end
                K_LSTART:   begin byte_a = MK_ONE;   byte_b = MK_ONE;  end
                K_PIXEL:    begin byte_a = lift(pix[PIX_W-1 -: BYTE_W]); byte_b = lift(peer); end
                K_BLANK_IN: begin byte_a = MK_ONE;   byte_b = MK_ZERO; end
                default:    begin byte_a = MK_ZERO;  byte_b = MK_ONE;  end
            endcase
        end
    end

    // Frame and left-align the selected word
    always_comb begin
        sa_word = {1'b1, sa_data, 1'b0};
        st_word = {1'b1, byte_a, byte_b, 1'b0};
        if (stereo_sel) word = SMAX'(st_word) << (SMAX - ST_SLOTS);
        else            word = SMAX'(sa_word) << (SMAX - SA_SLOTS);
    end

endmodule

// File: rtl/stpx_shifter.sv
// Shifter: counts bit slots of the current word, shifts it out MSB first
// and takes a new word on the edge after the last slot.
// Assumes: word_in is stable at that edge; the first edge after clear loads.
module stpx_shifter #(
    parameter int SA_SLOTS = 12,
    parameter int ST_SLOTS = 18,
    parameter int SMAX     = 18
) (
    input  logic            clk,
    input  logic            clr_n,
    input  logic            stereo_sel,
    input  logic            ser_en,
    input  logic [SMAX-1:0] word_in,
    output logic            load,
    output logic            ser_out,
    output logic            word_strobe
);

    localparam int CW = $clog2(SMAX);
    localparam logic [CW-1:0] SA_LAST = CW'(SA_SLOTS - 1);
    localparam logic [CW-1:0] ST_LAST = CW'(ST_SLOTS - 1);

    logic [CW-1:0]   slot_q;
    logic [SMAX-1:0] sh_q;
    logic            st_q;
    logic            started_q;
    logic [CW-1:0]   last;

    // Last slot index of the word in flight
    assign last        = st_q ? ST_LAST : SA_LAST;
    // Strobe marks the final slot; load also fires once right after clear
    assign word_strobe = started_q && (slot_q == last);
    assign load        = !started_q || (slot_q == last);
    // Output bit, held low while the driver is off
    assign ser_out     = ser_en & sh_q[SMAX-1];

    // Load a new word at a boundary, otherwise shift one slot
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            slot_q    <= '0;
            sh_q      <= '0;
            st_q      <= 1'b0;
            started_q <= 1'b0;
        end else if (load) begin
            sh_q      <= word_in;
            slot_q    <= '0;
            st_q      <= stereo_sel;
            started_q <= 1'b1;
        end else begin
            sh_q      <= sh_q << 1;
            slot_q    <= slot_q + 1'b1;
        end
    end

    // R12: the slot counter never passes the last slot of the current word
    p_slot_range_r12: assert property (@(posedge clk) disable iff (!clr_n)
        slot_q <= last);

    // R12: the word strobe lasts exactly one cycle
    p_strobe_single_r12: assert property (@(posedge clk) disable iff (!clr_n)
        word_strobe |=> !word_strobe);

    // R1: every word opens with a start bit (visible when the driver is on)
    p_start_bit_r1: assert property (@(posedge clk) disable iff (!clr_n)
        word_strobe |=> (ser_out == ser_en));

    // R2: the strobe slot carries the stop bit
    p_stop_bit_r2: assert property (@(posedge clk) disable iff (!clr_n)
        word_strobe |-> !ser_out);

endmodule

// File: rtl/stpx_serializer.sv
// Top: stereo/stand-alone pixel serializer with embedded strobes and a
// lockstep check. Clocked by the serial bit clock; one word per pixel.
// Assumes: inputs are held stable across each word's load edge.
module stpx_serializer
    import stpx_pkg::*;
#(
    parameter int                PIX_W    = 10,
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] RES_CODE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stereo_mode,
    input  logic              sync_force,
    input  logic              ser_en,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              lv_in,
    input  logic              fv_in,
    input  logic [BYTE_W-1:0] peer_byte,
    output logic              ser_out,
    output logic              word_strobe,
    output logic              stereo_err
);

    localparam int SA_SLOTS = PIX_W + 2;
    localparam int ST_SLOTS = 2 * BYTE_W + 2;
    localparam int SMAX     = (ST_SLOTS > SA_SLOTS) ? ST_SLOTS : SA_SLOTS;

    logic            clr_n;
    logic            load;
    word_kind_e      kind;
    logic [SMAX-1:0] word;

    // Hard and soft reset share one synchronous clear
    assign clr_n = rst_n & ~soft_rst;

    stpx_frame_track #(
        .BYTE_W   (BYTE_W),
        .RES_CODE (RES_CODE)
    ) u_track (
        .clk        (clk),
        .clr_n      (clr_n),
        .load       (load),
        .stereo_sel (stereo_mode),
        .sync_force (sync_force),
        .fv         (fv_in),
        .lv         (lv_in),
        .peer       (peer_byte),
        .kind       (kind),
        .err_flag   (stereo_err)
    );

    stpx_word_build #(
        .PIX_W    (PIX_W),
        .BYTE_W   (BYTE_W),
        .RES_CODE (RES_CODE),
        .SMAX     (SMAX)
    ) u_build (
        .stereo_sel (stereo_mode),
        .sync_force (sync_force),
        .lv         (lv_in),
        .kind       (kind),
        .pix        (pix_in),
        .peer       (peer_byte),
        .word       (word)
    );

    stpx_shifter #(
        .SA_SLOTS (SA_SLOTS),
        .ST_SLOTS (ST_SLOTS),
        .SMAX     (SMAX)
    ) u_shift (
        .clk         (clk),
        .clr_n       (clr_n),
        .stereo_sel  (stereo_mode),
        .ser_en      (ser_en),
        .word_in     (word),
        .load        (load),
        .ser_out     (ser_out),
        .word_strobe (word_strobe)
    );

    // R3: a stereo data word never carries a marker value in either byte
    p_marker_free_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (load && stereo_mode && !sync_force && kind == K_PIXEL) |->
        ((word[SMAX-2 -: BYTE_W] >= BYTE_W'(2)) && (word[SMAX-2-BYTE_W -: BYTE_W] >= BYTE_W'(2))));

endmodule

// File: tb/tb_stpx_serializer.sv
// Directed bench: each scenario task drives words, queues the expected
// framed word, and checks flags; a monitor collects and compares words.
module tb_stpx_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       stereo_mode = 1'b0;
    logic       sync_force = 1'b0;
    logic       ser_en = 1'b1;
    logic [9:0] pix_in = '0;
    logic       lv_in = 1'b0;
    logic       fv_in = 1'b0;
    logic [7:0] peer_byte = '0;
    logic       ser_out;
    logic       word_strobe;
    logic       stereo_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // next-word controls, applied by put()
    logic nx_st = 1'b0, nx_sync = 1'b0, nx_en = 1'b1;
    // reference framing state
    logic m_fvp = 1'b0, m_lo = 1'b0, m_rp = 1'b0, m_err = 1'b0;

    logic [17:0] exp_w[$];
    int          exp_n[$];
    string       exp_t[$];
    logic [17:0] acc = '0;
    int          cnt = 0;

    always #4 clk = ~clk;

    stpx_serializer dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stereo_mode(stereo_mode),
        .sync_force(sync_force), .ser_en(ser_en), .pix_in(pix_in), .lv_in(lv_in),
        .fv_in(fv_in), .peer_byte(peer_byte), .ser_out(ser_out),
        .word_strobe(word_strobe), .stereo_err(stereo_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: gather serial bits, compare each finished word
    always @(negedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt = 0;
            acc = '0;
        end else begin
            acc = {acc[16:0], ser_out};
            cnt++;
            if (word_strobe === 1'b1) begin
                if (exp_w.size() > 0) begin
                    logic [17:0] ew;
                    int en;
                    string et;
                    ew = exp_w.pop_front();
                    en = exp_n.pop_front();
                    et = exp_t.pop_front();
                    n_chk++;
                    if (cnt != en || acc != ew) begin
                        n_bad++;
                        $display("FAIL %s: got %0d slots word %0h expected %0d slots word %0h",
                                 et, cnt, acc, en, ew);
                    end
                end
                cnt = 0;
                acc = '0;
            end
        end
    end

    function automatic logic [7:0] lift(input logic [7:0] v);
        return (v < 8'd2) ? 8'd2 : v;
    endfunction

    // Drive one word's inputs, queue its expected image, wait for its strobe
    task automatic put(input logic [9:0] p, input logic l, input logic f,
                       input logic [7:0] pr, input string tag);
        logic [17:0] w;
        logic [7:0]  a, b;
        int          k;
        #1;
        stereo_mode = nx_st; sync_force = nx_sync; ser_en = nx_en;
        pix_in = p; lv_in = l; fv_in = f; peer_byte = pr;
        if (f && !m_fvp)      k = 0;
        else if (m_rp)        k = 1;
        else if (l && !m_lo)  k = 2;
        else if (l)           k = 3;
        else if (f)           k = 4;
        else                  k = 5;
        case (k)
            0:       begin a = 8'h00; b = 8'h00; end
            1:       begin a = 8'hA5; b = pr;    end
            2:       begin a = 8'h01; b = 8'h01; end
            3:       begin a = lift(p[9:2]); b = lift(pr); end
            4:       begin a = 8'h01; b = 8'h00; end
            default: begin a = 8'h00; b = 8'h01; end
        endcase
        if (nx_sync) begin a = 8'hFF; b = 8'h00; end
        if (nx_st) w = {1'b1, a, b, 1'b0};
        else       w = {6'b0, 1'b1, (nx_sync ? 10'h3E0 : (l ? p : 10'h000)), 1'b0};
        if (!nx_en) w = '0;
        if (!nx_sync) begin
            if (nx_st && k == 1 && pr != 8'hA5) m_err = 1'b1;
            m_lo  = l && (m_lo || k == 2);
            m_rp  = (k == 0);
            m_fvp = f;
        end
        exp_w.push_back(w);
        exp_n.push_back(nx_st ? 18 : 12);
        exp_t.push_back(tag);
        do @(negedge clk); while (word_strobe !== 1'b1);
    endtask

    // Hard reset with reset-state checks (R11); ends just before the first load
    task automatic do_reset();
        #1;
        rst_n = 1'b0;
        nx_st = 1'b0; nx_sync = 1'b0; nx_en = 1'b1;
        m_fvp = 1'b0; m_lo = 1'b0; m_rp = 1'b0; m_err = 1'b0;
        exp_w.delete(); exp_n.delete(); exp_t.delete();
        repeat (3) @(negedge clk);
        check("R11 ser_out in reset", ser_out, 0);
        check("R11 word_strobe in reset", word_strobe, 0);
        check("R11 stereo_err in reset", stereo_err, 0);
        #1 rst_n = 1'b1;
    endtask

    task automatic drained(input string tag);
        #1 check(tag, exp_w.size(), 0);
    endtask

    task automatic t_standalone();
        do_reset();
        put(10'h3FF, 1, 1, 8'h00, "R1 full-scale pixel");
        put(10'h000, 1, 1, 8'h00, "R1 zero pixel");
        put(10'h2A5, 1, 1, 8'h00, "R1 mixed pixel");
        put(10'h155, 0, 1, 8'h00, "R1 line low sends zero");
        drained("R12 stand-alone words delivered");
    endtask

    task automatic t_stereo_basic();
        do_reset();
        nx_st = 1'b1;
        put(10'h000, 0, 0, 8'h00, "R7 blanking outside frame");
        put(10'h000, 0, 1, 8'h11, "R4 frame-start marker");
        put(10'h000, 0, 1, 8'hA5, "R5 check word match");
        put(10'h000, 0, 1, 8'h00, "R7 blanking inside frame");
        put(10'h3FF, 1, 1, 8'h80, "R6 line-start marker");
        put(10'h3FF, 1, 1, 8'h80, "R2 merged data word");
        put(10'h003, 1, 1, 8'h01, "R3 lift 0x00 and 0x01");
        put(10'h007, 1, 1, 8'h02, "R3 lift local 0x01");
        put(10'h00B, 1, 1, 8'h00, "R3 local 0x02 kept, peer 0x00 lifted");
        put(10'h000, 0, 1, 8'h00, "R7 blanking between lines");
        put(10'h2A8, 1, 1, 8'h33, "R6 second line-start");
        put(10'h2A8, 1, 1, 8'h33, "R2 data word 0xAA/0x33");
        put(10'h000, 0, 0, 8'h00, "R7 blanking after frame");
        drained("R12 stereo words delivered");
        check("R5 no error on matching check word", stereo_err, 0);
    endtask

    task automatic t_deferred_line();
        do_reset();
        nx_st = 1'b1;
        put(10'h000, 0, 0, 8'h00, "R7 idle before frame");
        put(10'h100, 1, 1, 8'hA5, "R4 frame-start wins over line-start");
        put(10'h100, 1, 1, 8'hA5, "R5 check word while line high");
        put(10'h100, 1, 1, 8'h44, "R6 deferred line-start");
        put(10'h100, 1, 1, 8'h44, "R2 first data word 0x40/0x44");
        drained("R6 deferred words delivered");
    endtask

    task automatic t_mismatch_soft();
        do_reset();
        nx_st = 1'b1;
        put(10'h000, 0, 0, 8'h00, "R7 idle");
        put(10'h000, 0, 1, 8'h00, "R4 frame-start");
        put(10'h000, 0, 1, 8'h5A, "R5 check word mismatch");
        check("R5 flag set after mismatch", stereo_err, 1);
        put(10'h000, 0, 0, 8'h00, "R7 frame end");
        put(10'h000, 0, 1, 8'h00, "R4 next frame-start");
        put(10'h000, 0, 1, 8'hA5, "R5 matching check word");
        check("R5 flag stays set", stereo_err, 1);
        #1 soft_rst = 1'b1;
        @(negedge clk);
        check("R10 flag cleared by soft reset", stereo_err, 0);
        check("R10 strobe quiet in soft reset", word_strobe, 0);
        check("R10 output quiet in soft reset", ser_out, 0);
        #1 soft_rst = 1'b0;
        m_fvp = 1'b0; m_lo = 1'b0; m_rp = 1'b0; m_err = 1'b0;
        put(10'h000, 0, 1, 8'h00, "R10 frame restarts with frame-start");
        put(10'h000, 0, 1, 8'hA5, "R10 check word after restart");
        check("R10 flag clear after restart", stereo_err, 0);
        drained("R10 words delivered");
    endtask

    task automatic t_sync();
        do_reset();
        nx_sync = 1'b1;
        put(10'h123, 1, 1, 8'h00, "R8 stand-alone lock pattern");
        nx_sync = 1'b0;
        put(10'h123, 1, 1, 8'h00, "R8 stand-alone data resumes");
        nx_st = 1'b1;
        put(10'h000, 0, 0, 8'h00, "R12 mode switch to 18 slots");
        nx_sync = 1'b1;
        put(10'h000, 0, 1, 8'h77, "R8 stereo lock pattern");
        put(10'h000, 0, 1, 8'h77, "R8 stereo lock pattern held");
        nx_sync = 1'b0;
        put(10'h000, 0, 1, 8'h77, "R8 frame-start held through sync");
        put(10'h000, 0, 1, 8'hA5, "R8 check word after sync");
        nx_st = 1'b0;
        put(10'h2C3, 1, 1, 8'h00, "R12 mode switch back to 12 slots");
        drained("R8 words delivered");
    endtask

    task automatic t_enable();
        do_reset();
        nx_st = 1'b1;
        nx_en = 1'b0;
        put(10'h000, 0, 0, 8'h00, "R9 output off outside frame");
        put(10'h000, 0, 1, 8'h11, "R9 output off on frame-start");
        nx_en = 1'b1;
        put(10'h000, 0, 1, 8'hA5, "R9 framing advanced while off");
        nx_st = 1'b0;
        nx_en = 1'b0;
        put(10'h3FF, 1, 1, 8'h00, "R9 stand-alone output off");
        nx_en = 1'b1;
        put(10'h3FF, 1, 1, 8'h00, "R9 output back on");
        drained("R9 words delivered");
    endtask

    initial begin
        t_standalone();
        t_stereo_basic();
        t_deferred_line();
        t_mismatch_soft();
        t_sync();
        t_enable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule